// File: doc/BRIEF.md
# Latch-Framed Serial Register Port

This block is a serial slave that gives a host access to a small set of configuration registers. The host owns three lines: a control clock, a data input and an active-low latch. It frames each transfer by pulling the latch low, clocking in a fixed-length command word, and raising the latch again. The command word carries a register address, a direction bit, a reserved bit and a data field. A write lands in the register file only when the latch rises after a well-formed frame. A read returns the addressed register on a separate data output during the same frame. That output is enabled only while the latch is low.

All three host lines are brought into the system clock domain through synchroniser chains. Clock edges are detected from the synchronised copy of the control clock, so the host clock must be several system clocks slow per phase. The register file holds one volume word per output channel, a mute mask, a mode word and a word-length word. Each of these is presented as a parallel output to the surrounding logic.

Top module: `latch_ctrl_port`

## Requirements
- R1: After reset, every volume register holds all ones (full scale, 1023). The mute, mode and word-length registers hold zero, and `sdo_oe_o` is low.
- R2: A frame is 16 bits, most significant first, sampled on rising control clock edges. Bits 15:12 are the address. Bit 11 is the direction (0 = write, 1 = read). Bit 10 is reserved and must be 0 for a write to take effect. Bits 9:0 are the data.
- R3: A write takes effect only when the latch rises after exactly 16 rising control clock edges. A frame of any other length leaves every register unchanged.
- R4: Addresses 0 to NUM_VOL-1 select the volume registers. NUM_VOL selects the mute mask, NUM_VOL+1 the mode word and NUM_VOL+2 the word-length word. A write to any higher address changes nothing, and a read of such an address returns zero.
- R5: On a read, the addressed register is shifted out on `sdo_o` most significant bit first, in frame bit slots 9 down to 0. Each bit changes after a falling control clock edge and is valid at the following rising edge. A read frame alters no register, whatever its data field holds.
- R6: `sdo_oe_o` is high while the synchronised latch is low and low while it is high. `sdo_o` is 0 whenever `sdo_oe_o` is low.
- R7: Reset asserted at any time returns all registers to the values given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host control clock |
| sdi_i | input | 1 | Host serial data in |
| latch_ni | input | 1 | Frame latch, active low |
| sdo_o | output | 1 | Serial read data out |
| sdo_oe_o | output | 1 | Output enable for the three-state data pad |
| vol_o | output | NUM_VOL*10 | Volume words, channel 0 in the low bits |
| mute_o | output | 10 | Mute mask |
| mode_o | output | 10 | Mode word |
| wlen_o | output | 10 | Word-length word |

## Verification
The bench builds the block with NUM_VOL = 4 and SYNC_STAGES = 2. With these values the mute, mode and word-length registers sit at addresses 4, 5 and 6, and addresses 7 to 15 are unmapped. Writes and reads to unmapped addresses are therefore easy to reach alongside every mapped register. The host clock runs at 16 system clocks per period, so the synchroniser delay stays well inside one host clock phase.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 10;
  localparam int CNT_W   = 5;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              rsv;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/ctrl_port_sync.sv
module ctrl_port_sync #(
  parameter int          WIDTH     = 3,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctrl_port_shift.sv
module ctrl_port_shift
  import ctrl_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic              lat_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_W - DATA_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic               sclk_q, lat_q;
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  out_q;
  logic               rd_act_q;
  logic               sclk_rise, sclk_fall, lat_rise;
  frame_t             frm;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign sclk_fall = ~sclk_s_i & sclk_q;
  assign lat_rise  = lat_s_i & ~lat_q;
  assign frm       = frame_t'(sr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      lat_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      lat_q  <= lat_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      out_q    <= '0;
      rd_act_q <= 1'b0;
    end else if (lat_s_i) begin
      cnt_q    <= '0;
      out_q    <= '0;
      rd_act_q <= 1'b0;
    end else begin
      if (sclk_rise) begin
        sr_q <= {sr_q[FRAME_W-2:0], sdi_s_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (sclk_fall) begin
        if (cnt_q == CNT_HDR) begin
          out_q    <= rd_data_i;
          rd_act_q <= sr_q[1];
        end else if (cnt_q > CNT_HDR) begin
          out_q <= {out_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // header occupies sr_q[5:0] when cnt_q == CNT_HDR
  assign rd_addr_o = sr_q[FRAME_W-DATA_W-1 -: ADDR_W];
  assign wr_en_o   = lat_rise & (cnt_q == CNT_FULL) & ~frm.rd & ~frm.rsv;
  assign wr_addr_o = frm.addr;
  assign wr_data_o = frm.data;
  assign sdo_o     = rd_act_q & out_q[DATA_W-1];
endmodule

// File: rtl/ctrl_port_regs.sv
module ctrl_port_regs
  import ctrl_port_pkg::*;
#(
  parameter int NUM_VOL = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [NUM_VOL*DATA_W-1:0] vol_o,
  output logic [DATA_W-1:0]         mute_o,
  output logic [DATA_W-1:0]         mode_o,
  output logic [DATA_W-1:0]         wlen_o
);
  localparam logic [ADDR_W-1:0] A_MUTE = ADDR_W'(NUM_VOL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(NUM_VOL + 1);
  localparam logic [ADDR_W-1:0] A_WLEN = ADDR_W'(NUM_VOL + 2);

  logic [DATA_W-1:0] vol_q [NUM_VOL];
  logic [DATA_W-1:0] mute_q, mode_q, wlen_q;

  for (genvar i = 0; i < NUM_VOL; i++) begin : g_vol
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vol_q[i] <= '1;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i)) vol_q[i] <= wr_data_i;
    end
    assign vol_o[i*DATA_W +: DATA_W] = vol_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_q <= '0;
      mode_q <= '0;
      wlen_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_MUTE) mute_q <= wr_data_i;
      if (wr_addr_i == A_MODE) mode_q <= wr_data_i;
      if (wr_addr_i == A_WLEN) wlen_q <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_VOL; k++)
      if (rd_addr_i == ADDR_W'(k)) rd_data_o = vol_q[k];
    if (rd_addr_i == A_MUTE) rd_data_o = mute_q;
    if (rd_addr_i == A_MODE) rd_data_o = mode_q;
    if (rd_addr_i == A_WLEN) rd_data_o = wlen_q;
  end

  assign mute_o = mute_q;
  assign mode_o = mode_q;
  assign wlen_o = wlen_q;
endmodule

// File: rtl/latch_ctrl_port.sv
module latch_ctrl_port
  import ctrl_port_pkg::*;
#(
  parameter int NUM_VOL     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sclk_i,
  input  logic                      sdi_i,
  input  logic                      latch_ni,
  output logic                      sdo_o,
  output logic                      sdo_oe_o,
  output logic [NUM_VOL*DATA_W-1:0] vol_o,
  output logic [DATA_W-1:0]         mute_o,
  output logic [DATA_W-1:0]         mode_o,
  output logic [DATA_W-1:0]         wlen_o
);
  logic [2:0]        sync_q;
  logic              sdo_raw;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  // bit 2 latch (idles high), bit 1 data, bit 0 clock
  ctrl_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({latch_ni, sdi_i, sclk_i}),
    .q_o   (sync_q)
  );

  ctrl_port_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sync_q[0]),
    .sdi_s_i  (sync_q[1]),
    .lat_s_i  (sync_q[2]),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sdo_o    (sdo_raw)
  );

  ctrl_port_regs #(.NUM_VOL(NUM_VOL)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .vol_o    (vol_o),
    .mute_o   (mute_o),
    .mode_o   (mode_o),
    .wlen_o   (wlen_o)
  );

  assign sdo_oe_o = ~sync_q[2];
  assign sdo_o    = sdo_oe_o & sdo_raw;
endmodule

// File: rtl/latch_ctrl_port_chk.sv
module latch_ctrl_port_chk
  import ctrl_port_pkg::*;
#(
  parameter int NUM_VOL = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      sdo_o,
  input logic                      sdo_oe_o,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [NUM_VOL*DATA_W-1:0] vol_o,
  input logic [DATA_W-1:0]         mute_o,
  input logic [DATA_W-1:0]         mode_o,
  input logic [DATA_W-1:0]         wlen_o
);
  localparam logic [ADDR_W-1:0] A_MUTE = ADDR_W'(NUM_VOL);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(NUM_VOL + 2);

  AST_SDO_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o); // R6

  AST_VOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(vol_o)); // R3

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable({mute_o, mode_o, wlen_o})); // R3

  AST_WR_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> $past(sdo_oe_o) && !sdo_oe_o); // R3

  AST_MUTE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr != A_MUTE) |=> $stable(mute_o)); // R4

  AST_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr > A_TOP) |=> $stable({vol_o, mute_o, mode_o, wlen_o})); // R4
endmodule

bind latch_ctrl_port latch_ctrl_port_chk #(.NUM_VOL(NUM_VOL)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .vol_o   (vol_o),
  .mute_o  (mute_o),
  .mode_o  (mode_o),
  .wlen_o  (wlen_o)
);

// File: tb/latch_ctrl_port_bench.sv
`timescale 1ns/1ps
module latch_ctrl_port_bench;
  localparam int NV   = 4;
  localparam int DW   = 10;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, latch_n = 1'b1;
  logic sdo, sdo_oe;
  logic [NV*DW-1:0] vol;
  logic [DW-1:0] mute, mode, wlen;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_r [16];

  always #2.5 clk = ~clk;

  latch_ctrl_port #(.NUM_VOL(NV), .SYNC_STAGES(2)) u_latch_ctrl_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .latch_ni(latch_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .vol_o(vol), .mute_o(mute), .mode_o(mode), .wlen_o(wlen)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int a, input bit rd, input bit rsv, input int d);
    return {4'(a), rd, rsv, 10'(d)};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) exp_r[i] = (i < NV) ? 10'h3FF : 10'h000;
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NV; i++) chk({tag, " vol"}, int'(vol[i*DW +: DW]), int'(exp_r[i]));
    chk({tag, " mute"}, int'(mute), int'(exp_r[NV]));
    chk({tag, " mode"}, int'(mode), int'(exp_r[NV+1]));
    chk({tag, " wlen"}, int'(wlen), int'(exp_r[NV+2]));
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits,
                      output logic [DW-1:0] rd, output bit oe_ok);
    rd = '0;
    oe_ok = 1'b1;
    latch_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      #HALF;
      if (!sdo_oe) oe_ok = 1'b0;
      if (i >= 6 && i < 16) rd[15-i] = sdo;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    #HALF;
    latch_n = 1'b1;
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    logic [DW-1:0] r;
    bit ok;
    xfer(mk(a, 1'b0, 1'b0, d), 16, r, ok);
    if (a < NV + 3) exp_r[a] = 10'(d);
  endtask

  task automatic t_reset();
    model_reset();
    check_regs("R1 reset");
    chk("R1 oe idle", int'(sdo_oe), 0);
    chk("R6 sdo idle", int'(sdo), 0);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] r;
    bit ok;
    wr(2, 10'h155);
    check_regs("R2 write vol2");
    xfer(mk(2, 1'b1, 1'b0, 0), 16, r, ok);
    chk("R5 read vol2", int'(r), 'h155);
    chk("R6 oe in frame", int'(ok), 1);
    chk("R6 oe after frame", int'(sdo_oe), 0);
    xfer(mk(0, 1'b1, 1'b0, 0), 16, r, ok);
    chk("R5 read vol0 default", int'(r), 'h3FF);
  endtask

  task automatic t_cfg();
    logic [DW-1:0] r;
    bit ok;
    wr(NV, 10'h2AA);
    wr(NV + 1, 10'h003);
    wr(NV + 2, 10'h201);
    check_regs("R4 cfg write");
    xfer(mk(NV, 1'b1, 1'b0, 0), 16, r, ok);
    chk("R4 read mute", int'(r), 'h2AA);
    xfer(mk(NV + 2, 1'b1, 1'b0, 0), 16, r, ok);
    chk("R4 read wlen", int'(r), 'h201);
  endtask

  task automatic t_length();
    logic [DW-1:0] r;
    bit ok;
    xfer(mk(1, 1'b0, 1'b0, 'h0F0), 15, r, ok);
    check_regs("R3 short frame");
    xfer(mk(1, 1'b0, 1'b0, 'h0F0), 17, r, ok);
    check_regs("R3 long frame");
    wr(1, 10'h0F0);
    check_regs("R3 exact frame");
  endtask

  task automatic t_reserved();
    logic [DW-1:0] r;
    bit ok;
    xfer(mk(3, 1'b0, 1'b1, 'h011), 16, r, ok);
    check_regs("R2 reserved set");
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] r;
    bit ok;
    wr(9, 10'h3C3);
    wr(NV + 3, 10'h1E1);
    check_regs("R4 unmapped write");
    xfer(mk(9, 1'b1, 1'b0, 0), 16, r, ok);
    chk("R4 unmapped read", int'(r), 0);
  endtask

  task automatic t_read_side();
    logic [DW-1:0] r;
    bit ok;
    xfer(mk(0, 1'b1, 1'b0, 'h000), 16, r, ok);
    chk("R5 read vol0", int'(r), 'h3FF);
    xfer(mk(1, 1'b1, 1'b0, 'h3FF), 16, r, ok);
    chk("R5 read vol1", int'(r), 'h0F0);
    check_regs("R5 read no write");
  endtask

  task automatic t_midreset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    check_regs("R7 reset in run");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 oe after reset", int'(sdo_oe), 0);
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_write_read();
    t_cfg();
    t_length();
    t_reserved();
    t_unmapped();
    t_read_side();
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule